// File: doc/BRIEF.md
# Indirect Switch Register Access Engine

This block reaches switch registers that are not directly addressable. They are exposed through a two-register window on a management bus device. One register in the window is a command register carrying a busy flag. The other is a data register. A client hands the engine a single request: read or write, bus device address, internal port number, register number and, for a write, a 16-bit value. The engine then runs the whole handshake on its own. It polls the busy flag, moves the value through the data register and builds the command word. It finishes with a one-cycle done pulse and an error code, plus the register value when a read succeeds.

On its downstream side the engine drives a generic management access port. Each access is one register read or write on a bus device, closed by an acknowledge that returns read data and an error bit. Bit-level serial framing sits in whatever serves that port. The engine holds one transaction at a time and no more.

Top module: `swacc_indirect`

## Requirements
- R1: After reset, req_ready_o is 1, mb_req_o is 0, done_o is 0 and err_code_o is 0.
- R2: Every access goes to the device address latched from the request. Window register 0 is the command register and window register 1 is the data register.
- R3: An issued command word has bits 15:12 = 4'b1001. Bits 11:10 hold the opcode, 2'b10 for a read and 2'b01 for a write. Bits 9:5 hold the low 5 bits of the port number and bits 4:0 hold the low 5 bits of the register number.
- R4: A read performs these steps in order: busy wait, command write, busy wait, data register read. rdata_o at the done pulse equals the value the data register returned.
- R5: A write performs these steps in order: busy wait, data register write of the request value, command write, busy wait.
- R6: A busy wait reads the command register until bit 15 of the returned value is 0. No other bit of that value has any effect.
- R7: If POLL_MAX polls in one busy wait all read busy, the transaction ends with err_code_o = 2 (timeout) and makes no further access.
- R8: An acknowledge that carries mb_err_i ends the transaction at once with err_code_o = 1 (bus error) and makes no further access.
- R9: A request is accepted only when req_ready_o is 1. req_valid_i is ignored while a transaction is running.
- R10: Each accepted request produces exactly one done_o pulse, one cycle long. err_code_o is 0 (success), 1 or 2 during the pulse and 0 at all other times.
- R11: While mb_req_o is 1 and unacknowledged, mb_req_o and every access field stay unchanged.
- R12: After a timeout or a bus error the engine is idle, and the next request runs normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe |
| req_ready_o | output | 1 | Engine idle, request will be taken |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_dev_i | input | 5 | Bus device address of the window |
| req_port_i | input | 8 | Internal port number (low 5 bits used) |
| req_reg_i | input | 8 | Register number (low 5 bits used) |
| req_wdata_i | input | 16 | Write value |
| done_o | output | 1 | One-cycle completion pulse |
| err_code_o | output | 2 | 0 ok, 1 bus error, 2 timeout; valid with done_o |
| rdata_o | output | 16 | Read result, valid with done_o after a successful read |
| mb_req_o | output | 1 | Management access request |
| mb_we_o | output | 1 | Access is a write |
| mb_dev_o | output | 5 | Access device address |
| mb_reg_o | output | 5 | Access window register number |
| mb_wdata_o | output | 16 | Access write data |
| mb_ack_i | input | 1 | Access complete |
| mb_rdata_i | input | 16 | Access read data |
| mb_err_i | input | 1 | Access failed |

## Verification
The bench builds the engine with POLL_MAX = 4, so the timeout sits a few polls away. It sweeps the busy count of each of the two waits through every value from 0 to 4, for both reads and writes. That covers a pass on the first poll, a pass on the last allowed poll, and a timeout in either wait. With the window this short, a bus error can also be injected at every access position of a transaction. Acknowledge latencies of 0 to 2 cycles rotate through the runs.

// File: rtl/swacc_pkg.sv
package swacc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_POLL_PRE, ST_WR_DATA, ST_WR_CMD, ST_POLL_POST, ST_RD_DATA
  } st_e;

  typedef enum logic [1:0] {ERR_NONE = 2'd0, ERR_BUS = 2'd1, ERR_TMO = 2'd2} err_e;

  localparam int unsigned FLD_W  = 5;
  localparam int unsigned WORD_W = 16;
  localparam logic [FLD_W-1:0] WIN_CMD  = 5'd0;
  localparam logic [FLD_W-1:0] WIN_DATA = 5'd1;
  localparam logic [1:0] OP_RD = 2'b10;
  localparam logic [1:0] OP_WR = 2'b01;
  localparam int unsigned BUSY_BIT = 15;

  typedef struct packed {
    logic              wr;
    logic [FLD_W-1:0]  dev;
    logic [FLD_W-1:0]  port;
    logic [FLD_W-1:0]  regn;
    logic [WORD_W-1:0] wdata;
  } req_t;
endpackage

// File: rtl/swacc_cmd_fmt.sv
module swacc_cmd_fmt
  import swacc_pkg::*;
(
  input  logic              wr_i,
  input  logic [FLD_W-1:0]  port_i,
  input  logic [FLD_W-1:0]  regn_i,
  output logic [WORD_W-1:0] cmd_o
);
  logic [1:0] op;
  assign op    = wr_i ? OP_WR : OP_RD;
  assign cmd_o = {1'b1, 2'b00, 1'b1, op, port_i, regn_i};
endmodule

// File: rtl/swacc_poll_ctr.sv
module swacc_poll_ctr #(
  parameter int unsigned POLL_MAX = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);
  localparam int unsigned CNT_W = (POLL_MAX > 1) ? $clog2(POLL_MAX) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(POLL_MAX - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = (cnt_q == LAST);

  // the FSM must give up rather than count past the limit
  assert_no_inc_at_limit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i |-> !last_o);
  assert_cnt_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
endmodule

// File: rtl/swacc_bus_mux.sv
module swacc_bus_mux
  import swacc_pkg::*;
(
  input  st_e               state_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [WORD_W-1:0] cmd_i,
  output logic              we_o,
  output logic [FLD_W-1:0]  reg_o,
  output logic [WORD_W-1:0] wdata_o
);
  always_comb begin
    we_o    = 1'b0;
    reg_o   = WIN_CMD;
    wdata_o = '0;
    unique case (state_i)
      ST_WR_DATA: begin we_o = 1'b1; reg_o = WIN_DATA; wdata_o = wdata_i; end
      ST_WR_CMD:  begin we_o = 1'b1; reg_o = WIN_CMD;  wdata_o = cmd_i;   end
      ST_RD_DATA: reg_o = WIN_DATA;
      default:    ;
    endcase
  end
endmodule

// File: rtl/swacc_indirect.sv
module swacc_indirect
  import swacc_pkg::*;
#(
  parameter int unsigned POLL_MAX = 100,
  parameter int unsigned IN_W     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [FLD_W-1:0]  req_dev_i,
  input  logic [IN_W-1:0]   req_port_i,
  input  logic [IN_W-1:0]   req_reg_i,
  input  logic [WORD_W-1:0] req_wdata_i,
  output logic              done_o,
  output logic [1:0]        err_code_o,
  output logic [WORD_W-1:0] rdata_o,
  output logic              mb_req_o,
  output logic              mb_we_o,
  output logic [FLD_W-1:0]  mb_dev_o,
  output logic [FLD_W-1:0]  mb_reg_o,
  output logic [WORD_W-1:0] mb_wdata_o,
  input  logic              mb_ack_i,
  input  logic [WORD_W-1:0] mb_rdata_i,
  input  logic              mb_err_i
);
  st_e  state_q, state_d;
  req_t req_q;
  logic accept, polling, busy, last, inc, clr, fin;
  err_e fin_code;
  logic [WORD_W-1:0] cmd;

  assign req_ready_o = (state_q == ST_IDLE);
  assign accept      = req_valid_i && req_ready_o;
  assign mb_req_o    = !req_ready_o;
  assign mb_dev_o    = req_q.dev;
  assign polling     = (state_q == ST_POLL_PRE) || (state_q == ST_POLL_POST);
  assign busy        = mb_rdata_i[BUSY_BIT];

  swacc_cmd_fmt u_fmt (
    .wr_i(req_q.wr), .port_i(req_q.port), .regn_i(req_q.regn), .cmd_o(cmd)
  );

  swacc_bus_mux u_mux (
    .state_i(state_q), .wdata_i(req_q.wdata), .cmd_i(cmd),
    .we_o(mb_we_o), .reg_o(mb_reg_o), .wdata_o(mb_wdata_o)
  );

  assign inc = polling && mb_ack_i && !mb_err_i && busy && !last;
  assign clr = accept || (state_q == ST_WR_CMD && mb_ack_i);

  swacc_poll_ctr #(.POLL_MAX(POLL_MAX)) u_poll (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr), .inc_i(inc), .last_o(last)
  );

  always_comb begin
    state_d  = state_q;
    fin      = 1'b0;
    fin_code = ERR_NONE;
    if (accept) state_d = ST_POLL_PRE;
    else if (mb_req_o && mb_ack_i) begin
      if (mb_err_i) begin
        fin = 1'b1; fin_code = ERR_BUS; state_d = ST_IDLE;
      end else begin
        unique case (state_q)
          ST_POLL_PRE, ST_POLL_POST: begin
            if (busy) begin
              if (last) begin fin = 1'b1; fin_code = ERR_TMO; state_d = ST_IDLE; end
            end else if (state_q == ST_POLL_PRE) begin
              state_d = req_q.wr ? ST_WR_DATA : ST_WR_CMD;
            end else if (req_q.wr) begin
              fin = 1'b1; state_d = ST_IDLE;
            end else begin
              state_d = ST_RD_DATA;
            end
          end
          ST_WR_DATA: state_d = ST_WR_CMD;
          ST_WR_CMD:  state_d = ST_POLL_POST;
          ST_RD_DATA: begin fin = 1'b1; state_d = ST_IDLE; end
          default:    state_d = ST_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      req_q      <= '0;
      done_o     <= 1'b0;
      err_code_o <= ERR_NONE;
      rdata_o    <= '0;
    end else begin
      state_q    <= state_d;
      done_o     <= fin;
      err_code_o <= fin ? fin_code : ERR_NONE;
      if (accept)
        req_q <= '{wr: req_write_i, dev: req_dev_i, port: req_port_i[FLD_W-1:0],
                   regn: req_reg_i[FLD_W-1:0], wdata: req_wdata_i};
      if (state_q == ST_RD_DATA && mb_ack_i && !mb_err_i) rdata_o <= mb_rdata_i;
    end
  end

  assert_req_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mb_req_o && !mb_ack_i |=> mb_req_o && $stable(mb_we_o) && $stable(mb_reg_o)
      && $stable(mb_wdata_o) && $stable(mb_dev_o));
  assert_cmd_header_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mb_req_o && mb_we_o && mb_reg_o == WIN_CMD |->
      mb_wdata_o[15:12] == 4'b1001 && (mb_wdata_o[11:10] == OP_RD || mb_wdata_o[11:10] == OP_WR));
  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_err_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> err_code_o == ERR_NONE);
  assert_done_idle_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> req_ready_o && !mb_req_o);
  assert_accept_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mb_req_o && req_valid_i |=> mb_req_o || done_o);
endmodule

// File: tb/tb_swacc_indirect.sv
module tb_swacc_indirect;
  localparam int PM = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic req_valid = 0, req_ready, req_write = 0;
  logic [4:0] req_dev = 0;
  logic [7:0] req_port = 0, req_reg = 0;
  logic [15:0] req_wdata = 0;
  logic done;
  logic [1:0] err_code;
  logic [15:0] rdata;
  logic mb_req, mb_we;
  logic [4:0] mb_dev, mb_reg;
  logic [15:0] mb_wdata;
  logic mb_ack = 0, mb_err = 0;
  logic [15:0] mb_rdata = 0;

  swacc_indirect #(.POLL_MAX(PM)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_dev_i(req_dev), .req_port_i(req_port), .req_reg_i(req_reg), .req_wdata_i(req_wdata),
    .done_o(done), .err_code_o(err_code), .rdata_o(rdata),
    .mb_req_o(mb_req), .mb_we_o(mb_we), .mb_dev_o(mb_dev), .mb_reg_o(mb_reg),
    .mb_wdata_o(mb_wdata), .mb_ack_i(mb_ack), .mb_rdata_i(mb_rdata), .mb_err_i(mb_err)
  );

  int n_chk = 0, n_bad = 0;
  task automatic chk(bit ok, string rq, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s act=%0h exp=%0h", rq, what, act, exp);
    end
  endtask

  // expected access script
  logic        e_we [16];
  logic [4:0]  e_reg[16];
  logic [15:0] e_wd [16];
  logic [15:0] e_rd [16];
  int e_n = 0, acc_idx = 0, err_at = 99, lat = 0, wait_cnt = 0;
  logic [4:0] e_dev = 0;

  task automatic add(logic we, logic [4:0] r, logic [15:0] wd, logic [15:0] rd);
    e_we[e_n] = we; e_reg[e_n] = r; e_wd[e_n] = wd; e_rd[e_n] = rd; e_n++;
  endtask

  // busy wait script: b busy reads then one idle read, or PM busy reads (timeout)
  task automatic add_wait(int b, output bit tmo);
    tmo = 0;
    for (int i = 0; i < PM; i++) begin
      if (i < b) add(0, 5'd0, 16'h0, 16'h8000 | 16'(i));
      else begin add(0, 5'd0, 16'h0, 16'h7ffe); return; end
    end
    tmo = 1;
  endtask

  task automatic build(bit wr, logic [7:0] port, logic [7:0] rg, logic [15:0] wd,
                       int bpre, int bpost, output logic [1:0] code, output logic [15:0] rv);
    bit tmo;
    logic [15:0] cmd;
    e_n = 0; code = 2'd0;
    cmd = 16'h9000 | (wr ? 16'h0400 : 16'h0800) | (16'(port[4:0]) << 5) | 16'(rg[4:0]);
    rv = {port[4:0], rg[4:0], 6'h15} ^ 16'ha5a5;
    add_wait(bpre, tmo);
    if (tmo) code = 2'd2;
    else begin
      if (wr) add(1, 5'd1, wd, 16'h0);
      add(1, 5'd0, cmd, 16'h0);
      add_wait(bpost, tmo);
      if (tmo) code = 2'd2;
      else if (!wr) add(0, 5'd1, 16'h0, rv);
    end
    if (err_at < e_n) begin e_n = err_at + 1; code = 2'd1; end
  endtask

  // bus responder: checks each access against the script (R2 R3 R4 R5 R6)
  initial forever begin
    @(negedge clk);
    mb_ack = 0; mb_err = 0; mb_rdata = 16'h0;
    if (rst_n && mb_req) begin
      if (wait_cnt < lat) wait_cnt++;
      else begin
        wait_cnt = 0;
        if (acc_idx >= e_n)
          chk(0, "R7/R8", "extra access idx", acc_idx, e_n);
        else begin
          chk(mb_we == e_we[acc_idx] && mb_reg == e_reg[acc_idx] && mb_dev == e_dev &&
              (!mb_we || mb_wdata == e_wd[acc_idx]), "R2/R3/R4/R5/R6",
              "access {we,reg,wdata}", {mb_we, mb_reg, mb_wdata},
              {e_we[acc_idx], e_reg[acc_idx], e_wd[acc_idx]});
          mb_rdata = e_rd[acc_idx];
          mb_err = (acc_idx == err_at);
        end
        mb_ack = 1;
        acc_idx++;
      end
    end
  end

  task automatic run(bit wr, logic [4:0] dev, logic [7:0] port, logic [7:0] rg,
                     logic [15:0] wd, int bpre, int bpost, bit intrude, string tag);
    logic [1:0] code;
    logic [15:0] rv;
    int cyc;
    build(wr, port, rg, wd, bpre, bpost, code, rv);
    e_dev = dev; acc_idx = 0; wait_cnt = 0;
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = wr; req_dev = dev; req_port = port; req_reg = rg; req_wdata = wd;
    @(negedge clk);
    if (intrude) begin  // R9: different request while busy must be ignored
      req_write = !wr; req_dev = ~dev; req_port = ~port; req_reg = ~rg; req_wdata = ~wd;
      @(negedge clk);
    end
    req_valid = 0;
    cyc = 0;
    while (!done && cyc < 2000) begin @(negedge clk); cyc++; end
    chk(done, tag, "done seen", done, 1);
    chk(err_code == code, tag, "err_code R7/R8/R10", err_code, code);
    if (!wr && code == 2'd0) chk(rdata == rv, "R4", "read data", rdata, rv);
    @(negedge clk);
    chk(!done && err_code == 0 && req_ready, "R10/R12", "pulse end {done,code,rdy}",
        {done, err_code, req_ready}, 1);
    chk(acc_idx == e_n, tag, "access count", acc_idx, e_n);
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(req_ready && !mb_req && !done && err_code == 0, "R1", "reset {rdy,req,done,code}",
        {req_ready, mb_req, done, err_code}, 5'b10000);
    rst_n = 1;
    @(negedge clk);
    // sweep of busy counts in both waits, both directions
    for (int wr = 0; wr < 2; wr++)
      for (int bp = 0; bp <= PM; bp++)
        for (int bq = 0; bq <= PM; bq++) begin
          lat = (bp + bq + wr) % 3;
          run(wr[0], 5'(bp * 3 + bq + 1), 8'hA0 | 8'(bp * 5 + bq), 8'hE0 | 8'(bq * 6 + bp + wr),
              16'(bp * 16'h1111 + bq * 16'h0101 + wr), bp, bq, 0, "R6/R7");
        end
    // bus error at every access position
    for (int wr = 0; wr < 2; wr++)
      for (int ea = 0; ea < 9; ea++) begin
        err_at = ea; lat = ea % 2;
        run(wr[0], 5'd9, 8'h13, 8'h07, 16'hbeef, 1, 2, 0, "R8");
        err_at = 99;
        // R12 engine recovers after error
        run(!wr[0], 5'd9, 8'h05, 8'h1c, 16'h1234, 0, 1, 0, "R12");
      end
    // R12 after timeout
    run(0, 5'd3, 8'h01, 8'h02, 16'h0, PM, 0, 0, "R7");
    run(0, 5'd3, 8'h1f, 8'h1f, 16'h0, 0, 0, 0, "R12");
    // R9 intruding request, R11 with slow acknowledge
    lat = 2;
    run(0, 5'd7, 8'h11, 8'h0a, 16'h0, 0, 0, 1, "R9");
    run(1, 5'd7, 8'h11, 8'h0a, 16'h5a5a, 0, 0, 1, "R9/R11");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule